// File: doc/BRIEF.md
# Programmable Three-Channel Colour Matrix

This block turns a stream of 8-bit, three-component pixels into three new components. Each output channel is a weighted sum of the three input components plus a constant. The result is multiplied by a power-of-two gain, rounded, and then clamped into an 8-bit range. With suitable settings the same hardware converts RGB to YCbCr, converts YCbCr back to RGB, or passes RGB through bit-exact.

Software loads nine matrix weights, three channel constants and a mode word through a simple write port. These writes land in shadow storage. The settings in use change only when a frame-start pulse arrives, so every pixel of a frame uses one matrix. Pixels enter and leave on a valid/ready stream through three register stages. A stall at the output holds the whole pipe.

Component k of a pixel lies in bits [8k+7:8k]. For RGB the components are R, G, B in the order k = 0, 1, 2. For YCbCr they are Y, Cb, Cr in the same order.

Top module: `color_matrix_top`

## Requirements
- R1: Write addresses 0..8 hold the weights. Address 3*c+k is the weight of input component k in output channel c. Each weight is a 9-bit two's-complement value taken from cfgData[8:0]. With scale code 1, the weight is the value divided by 256.
- R2: Write addresses 9, 10 and 11 hold the constants of channels 0, 1 and 2, taken from cfgData[12:0]. Each constant is 13-bit two's complement in quarter-LSB units, so it adds value*64 before the final divide by 256.
- R3: Address 12 holds the mode word. Bits [1:0] are the scale code s, which multiplies the result by 2^(s-1) (s = 0 gives half, 3 gives four times). Bit 2 is the saturation mode.
- R4: Each output is floor((acc*2^s + 256) / 512), where acc is the sum of the weighted components plus constant*64. A half-LSB result rounds upward.
- R5: With saturation mode 0, each output is clamped to 0..255, for negative and for overflowing results alike.
- R6: With saturation mode 1, channel 0 is clamped to 16..235, and channels 1 and 2 are clamped to 16..240.
- R7: Weights of 128 on the diagonal and 0 elsewhere, zero constants and scale code 2 give an output equal to the input pixel.
- R8: A pixel accepted on a clock edge is presented with outValid high after the third edge, counting the accepting edge as the first. The pipe never holds more than three pixels.
- R9: inReady is low only while outValid is high and outReady is low. While stalled, outPix stays stable, and pixels leave in the order they entered.
- R10: Settings written through the port take no effect until a frameStart pulse. On that pulse all shadow values become active together.
- R11: After reset, outValid is low, inReady is high and every active setting is zero, so any pixel produces 0x000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgWe | input | 1 | Write strobe for the setting port |
| cfgAddr | input | 4 | Setting address: 0..8 weights, 9..11 constants, 12 mode |
| cfgData | input | 16 | Setting write data |
| frameStart | input | 1 | One-cycle pulse that applies the shadow settings |
| inValid | input | 1 | Input pixel valid |
| inReady | output | 1 | Block can accept a pixel this cycle |
| inPix | input | 24 | Input pixel, component k at bits [8k+7:8k] |
| outValid | output | 1 | Output pixel valid |
| outReady | input | 1 | Downstream accepts the output pixel |
| outPix | output | 24 | Output pixel, channel c at bits [8c+7:8c] |

## Verification
The bench builds the block with its default parameters: 8-bit components, 9-bit weights, 13-bit constants and a 2-bit scale code. Every one of the four gain settings can therefore be selected, and both clamp limits can be reached from ordinary 8-bit pixels. At these widths the accumulator also carries the full negative range, so the lower clamp is exercised by a real underflow during YCbCr-to-RGB conversion of black. A rounding tie at scale 0 is exercised as well.

// File: rtl/cm_pkg.sv
package cm_pkg;
  localparam int NCH        = 3;
  localparam int PIPE_DEPTH = 3;
  localparam int SCALE_W    = 2;
  localparam int LIM_LO     = 16;
  localparam int LIM_LUMA   = 235;
  localparam int LIM_CHROMA = 240;

  typedef struct packed {
    logic capture;   // a new pixel enters stage 1
    logic advance;   // the whole pipe moves one stage
  } cmStrobeT;
endpackage

// File: rtl/cm_ctrl.sv
module cm_ctrl
  import cm_pkg::*;
#(
  parameter int COEF_W = 9,
  parameter int OFF_W  = 13,
  parameter int CFG_AW = 4,
  parameter int CFG_DW = 16
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           cfgWe,
  input  logic [CFG_AW-1:0]              cfgAddr,
  input  logic [CFG_DW-1:0]              cfgData,
  input  logic                           frameStart,
  input  logic                           inValid,
  input  logic                           outReady,
  output logic                           inReady,
  output logic                           outValid,
  output cmStrobeT                       strobe,
  output logic [NCH*NCH-1:0][COEF_W-1:0] coefAct,
  output logic [NCH-1:0][OFF_W-1:0]      offAct,
  output logic [SCALE_W-1:0]             scaleAct,
  output logic                           satAct
);
  localparam int NCOEF     = NCH * NCH;
  localparam int ADDR_OFF0 = NCOEF;
  localparam int ADDR_MODE = NCOEF + NCH;
  localparam int MODE_W    = SCALE_W + 1;

  logic [PIPE_DEPTH-1:0]           vPipe;
  logic [NCOEF-1:0][COEF_W-1:0]    coefSh;
  logic [NCH-1:0][OFF_W-1:0]       offSh;
  logic [MODE_W-1:0]               modeSh, modeAct;
  logic                            advance;

  assign advance  = outReady || !vPipe[PIPE_DEPTH-1];
  assign inReady  = advance;
  assign outValid = vPipe[PIPE_DEPTH-1];
  assign strobe   = '{capture: inValid && advance, advance: advance};
  assign scaleAct = modeAct[SCALE_W-1:0];
  assign satAct   = modeAct[SCALE_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) vPipe <= '0;
    else if (advance) vPipe <= {vPipe[PIPE_DEPTH-2:0], inValid};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      coefSh  <= '0;
      offSh   <= '0;
      modeSh  <= '0;
      coefAct <= '0;
      offAct  <= '0;
      modeAct <= '0;
    end else begin
      if (cfgWe) begin
        for (int i = 0; i < NCOEF; i++)
          if (cfgAddr == CFG_AW'(i)) coefSh[i] <= cfgData[COEF_W-1:0];
        for (int i = 0; i < NCH; i++)
          if (cfgAddr == CFG_AW'(ADDR_OFF0 + i)) offSh[i] <= cfgData[OFF_W-1:0];
        if (cfgAddr == CFG_AW'(ADDR_MODE)) modeSh <= cfgData[MODE_W-1:0];
      end
      if (frameStart) begin
        coefAct <= coefSh;
        offAct  <= offSh;
        modeAct <= modeSh;
      end
    end
  end
endmodule

// File: rtl/cm_datapath.sv
module cm_datapath
  import cm_pkg::*;
#(
  parameter int PIX_W     = 8,
  parameter int COEF_W    = 9,
  parameter int OFF_W     = 13,
  parameter int FRAC_BITS = 8
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  cmStrobeT                       strobe,
  input  logic [NCH*PIX_W-1:0]           inPix,
  input  logic [NCH*NCH-1:0][COEF_W-1:0] coefAct,
  input  logic [NCH-1:0][OFF_W-1:0]      offAct,
  input  logic [SCALE_W-1:0]             scaleAct,
  input  logic                           satAct,
  output logic [NCH*PIX_W-1:0]           outPix
);
  localparam int PROD_W    = COEF_W + PIX_W + 1;
  localparam int OFF_SHIFT = FRAC_BITS - 2;
  localparam int SUM_W     = PROD_W + $clog2(NCH);
  localparam int OFFX_W    = OFF_W + OFF_SHIFT;
  localparam int ACC_W     = ((SUM_W > OFFX_W) ? SUM_W : OFFX_W) + 1;
  localparam int SCALE_MAX = (1 << SCALE_W) - 1;
  localparam int SCL_W     = ACC_W + SCALE_MAX + 1;
  localparam int ROUND     = 1 << FRAC_BITS;
  localparam int PIX_MAX   = (1 << PIX_W) - 1;

  logic [SCALE_W-1:0] scale1Q, scale2Q;
  logic               sat1Q, sat2Q;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      scale1Q <= '0; sat1Q <= 1'b0;
      scale2Q <= '0; sat2Q <= 1'b0;
    end else if (strobe.advance) begin
      if (strobe.capture) begin
        scale1Q <= scaleAct;
        sat1Q   <= satAct;
      end
      scale2Q <= scale1Q;
      sat2Q   <= sat1Q;
    end
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : gChan
    localparam int HI_LIM = (ch == 0) ? LIM_LUMA : LIM_CHROMA;

    logic signed [PROD_W-1:0] prodQ [NCH];
    logic        [OFF_W-1:0]  off1Q;
    logic signed [ACC_W-1:0]  accD, accQ;
    logic signed [SCL_W-1:0]  scaled, shifted, lo, hi;
    logic        [PIX_W-1:0]  pixD, pixQ;

    // stage 1: weighted components
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        for (int k = 0; k < NCH; k++) prodQ[k] <= '0;
        off1Q <= '0;
      end else if (strobe.capture) begin
        for (int k = 0; k < NCH; k++)
          prodQ[k] <= PROD_W'($signed(coefAct[ch*NCH+k])) *
                      PROD_W'($signed({1'b0, inPix[k*PIX_W +: PIX_W]}));
        off1Q <= offAct[ch];
      end
    end

    // stage 2: sum plus aligned constant
    always_comb begin
      accD = ACC_W'($signed(off1Q)) <<< OFF_SHIFT;
      for (int k = 0; k < NCH; k++) accD = accD + ACC_W'(prodQ[k]);
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) accQ <= '0;
      else if (strobe.advance) accQ <= accD;
    end

    // stage 3: gain, round, clamp
    always_comb begin
      scaled  = (SCL_W'(accQ) <<< scale2Q) + SCL_W'(ROUND);
      shifted = scaled >>> (FRAC_BITS + 1);
      lo      = sat2Q ? SCL_W'(LIM_LO) : '0;
      hi      = sat2Q ? SCL_W'(HI_LIM) : SCL_W'(PIX_MAX);
      if (shifted < lo)      pixD = lo[PIX_W-1:0];
      else if (shifted > hi) pixD = hi[PIX_W-1:0];
      else                   pixD = shifted[PIX_W-1:0];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) pixQ <= '0;
      else if (strobe.advance) pixQ <= pixD;
    end

    assign outPix[ch*PIX_W +: PIX_W] = pixQ;
  end
endmodule

// File: rtl/color_matrix_top.sv
module color_matrix_top
  import cm_pkg::*;
#(
  parameter int PIX_W     = 8,
  parameter int COEF_W    = 9,
  parameter int OFF_W     = 13,
  parameter int FRAC_BITS = 8,
  parameter int CFG_AW    = 4,
  parameter int CFG_DW    = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgWe,
  input  logic [CFG_AW-1:0]    cfgAddr,
  input  logic [CFG_DW-1:0]    cfgData,
  input  logic                 frameStart,
  input  logic                 inValid,
  output logic                 inReady,
  input  logic [NCH*PIX_W-1:0] inPix,
  output logic                 outValid,
  input  logic                 outReady,
  output logic [NCH*PIX_W-1:0] outPix
);
  localparam int NCOEF   = NCH * NCH;
  localparam int PIX_BUS = NCH * PIX_W;

  cmStrobeT                     strobe;
  logic [NCOEF-1:0][COEF_W-1:0] coefAct;
  logic [NCH-1:0][OFF_W-1:0]    offAct;
  logic [SCALE_W-1:0]           scaleAct;
  logic                         satAct;

  cm_ctrl #(.COEF_W(COEF_W), .OFF_W(OFF_W), .CFG_AW(CFG_AW), .CFG_DW(CFG_DW)) uCtrl (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .frameStart(frameStart), .inValid(inValid), .outReady(outReady),
    .inReady(inReady), .outValid(outValid), .strobe(strobe),
    .coefAct(coefAct), .offAct(offAct), .scaleAct(scaleAct), .satAct(satAct)
  );

  cm_datapath #(.PIX_W(PIX_W), .COEF_W(COEF_W), .OFF_W(OFF_W), .FRAC_BITS(FRAC_BITS)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .inPix(inPix),
    .coefAct(coefAct), .offAct(offAct), .scaleAct(scaleAct), .satAct(satAct),
    .outPix(outPix)
  );
endmodule

// File: rtl/cm_checker.sv
module cm_checker
  import cm_pkg::*;
#(
  parameter int PIX_BUS = 24,
  parameter int NCOEF   = 9,
  parameter int COEF_W  = 9,
  parameter int OFF_W   = 13
) (
  input logic                         clk,
  input logic                         rstN,
  input logic                         inValid,
  input logic                         inReady,
  input logic                         outValid,
  input logic                         outReady,
  input logic [PIX_BUS-1:0]           outPix,
  input logic                         frameStart,
  input logic [NCOEF-1:0][COEF_W-1:0] coefAct,
  input logic [NCH-1:0][OFF_W-1:0]    offAct,
  input logic [SCALE_W-1:0]           scaleAct,
  input logic                         satAct
);
  logic [3:0] inFlight;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) inFlight <= '0;
    else inFlight <= inFlight + 4'(inValid && inReady) - 4'(outValid && outReady);
  end

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outPix));

  // R9
  ready_rule_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inReady |-> outValid && !outReady);

  // R8
  depth_limit_chk: assert property (@(posedge clk) disable iff (!rstN)
    inFlight <= 4'(PIPE_DEPTH));

  // R8
  no_phantom_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> inFlight != 4'd0);

  // R10
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !frameStart |=> $stable(coefAct) && $stable(offAct) && $stable(scaleAct) && $stable(satAct));
endmodule

bind color_matrix_top cm_checker #(
  .PIX_BUS(PIX_BUS), .NCOEF(NCOEF), .COEF_W(COEF_W), .OFF_W(OFF_W)
) uChk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
  .outValid(outValid), .outReady(outReady), .outPix(outPix),
  .frameStart(frameStart), .coefAct(coefAct), .offAct(offAct),
  .scaleAct(scaleAct), .satAct(satAct)
);

// File: tb/tb_color_matrix_top.sv
`timescale 1ns/1ps
module tb_color_matrix_top;
  logic        clk = 1'b0;
  logic        rstN;
  logic        cfgWe;
  logic [3:0]  cfgAddr;
  logic [15:0] cfgData;
  logic        frameStart;
  logic        inValid;
  logic        inReady;
  logic [23:0] inPix;
  logic        outValid;
  logic        outReady;
  logic [23:0] outPix;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  color_matrix_top dut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .frameStart(frameStart), .inValid(inValid), .inReady(inReady), .inPix(inPix),
    .outValid(outValid), .outReady(outReady), .outPix(outPix)
  );

  // matrix sets: 0 RGB->YCbCr, 1 YCbCr->RGB, 2 pass-through
  localparam int R2Y_C[9]  = '{'h042, 'h081, 'h019, 'h1DA, 'h1B6, 'h070, 'h070, 'h1A2, 'h1EE};
  localparam int Y2R_C[9]  = '{149, 0, 204, 149, 462, 408, 149, 255, 0};
  localparam int PASS_C[9] = '{128, 0, 0, 0, 128, 0, 0, 0, 128};
  localparam int R2Y_O[3]  = '{'h040, 'h200, 'h200};
  localparam int Y2R_O[3]  = '{8192 - 446, 266, 8192 - 554};

  // {set[1:0], input pixel, expected pixel}
  localparam int NVEC = 13;
  localparam logic [49:0] VEC [NVEC] = '{
    {2'd0, 24'hFFFFFF, 24'h8080EB},
    {2'd0, 24'h000000, 24'h808010},
    {2'd0, 24'h0000FF, 24'hF05A52},
    {2'd0, 24'hFF0000, 24'h6EF029},
    {2'd1, 24'h808010, 24'h000000},
    {2'd1, 24'h8080EB, 24'hFCFDFF},
    {2'd1, 24'h808080, 24'h7F8082},
    {2'd2, 24'h123456, 24'h123456},
    {2'd2, 24'hFF00A5, 24'hFF00A5},
    {2'd2, 24'h01FE7F, 24'h01FE7F},
    {2'd2, 24'h000000, 24'h000000},
    {2'd2, 24'hFFFFFF, 24'hFFFFFF},
    {2'd2, 24'h80017E, 24'h80017E}
  };

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    cfgWe   = 1'b1;
    cfgAddr = 4'(a);
    cfgData = 16'(d);
    @(negedge clk);
    cfgWe   = 1'b0;
  endtask

  task automatic pulseFrame();
    @(negedge clk);
    frameStart = 1'b1;
    @(negedge clk);
    frameStart = 1'b0;
  endtask

  task automatic loadSet(input int s, input int mode);
    for (int i = 0; i < 9; i++)
      wr(i, (s == 0) ? R2Y_C[i] : (s == 1) ? Y2R_C[i] : PASS_C[i]);
    for (int i = 0; i < 3; i++)
      wr(9 + i, (s == 0) ? R2Y_O[i] : (s == 1) ? Y2R_O[i] : 0);
    wr(12, mode);
  endtask

  task automatic runPixel(input logic [23:0] px, input logic [23:0] ex, input string tag);
    int lat;
    @(negedge clk);
    inValid = 1'b1;
    inPix   = px;
    while (!inReady) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    inValid = 1'b0;
    lat = 1;
    while (!outValid && lat < 8) begin
      @(negedge clk);
      lat++;
    end
    check(lat == 3, "R8 latency", 32'(lat), 32'd3);
    check(outPix == ex, tag, 32'(outPix), 32'(ex));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run hung, requirements R8 R9 unresolved");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; cfgWe = 1'b0; cfgAddr = '0; cfgData = '0; frameStart = 1'b0;
    inValid = 1'b0; inPix = '0; outReady = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(outValid == 1'b0, "R11 outValid in reset", 32'(outValid), 32'd0);
    check(inReady == 1'b1, "R11 inReady in reset", 32'(inReady), 32'd1);
    rstN = 1'b1;

    // R11: zero settings after reset
    runPixel(24'hFFFFFF, 24'h000000, "R11 zero settings");

    // R10: shadow writes wait for frame start
    loadSet(0, 1);
    pulseFrame();
    loadSet(2, 2);
    runPixel(24'hFFFFFF, 24'h8080EB, "R10 old matrix kept");
    pulseFrame();
    runPixel(24'hFFFFFF, 24'hFFFFFF, "R10 new matrix applied");

    // table walk: R1 conversions, R7 pass-through
    for (int v = 0; v < NVEC; v++) begin
      int s;
      s = int'(VEC[v][49:48]);
      if (v == 0 || VEC[v][49:48] != VEC[v-1][49:48]) begin
        loadSet(s, (s == 0) ? 1 : 2);
        pulseFrame();
      end
      runPixel(VEC[v][47:24], VEC[v][23:0], (s == 2) ? "R7 pass-through" : "R1 matrix conversion");
    end

    // R3 / R5: scale 3 doubles the half-gain diagonal, clamps high
    wr(12, 3);
    pulseFrame();
    runPixel(24'h0A28C8, 24'h1450FF, "R3 R5 scale 3 with clamp");
    // R3: scale 1 gives half gain
    wr(12, 1);
    pulseFrame();
    runPixel(24'h00FF03, 24'h008002, "R3 scale 1 half gain");
    // R4: scale 0 rounding ties upward
    wr(12, 0);
    pulseFrame();
    runPixel(24'h06090A, 24'h020203, "R4 rounding");

    // R6: limited range clamps
    wr(12, 2 | 4);
    pulseFrame();
    runPixel(24'hFFFF00, 24'hF0F010, "R6 limited clamp");
    runPixel(24'h0000EC, 24'h1010EB, "R6 luma upper limit");
    runPixel(24'h00EC05, 24'h10EC10, "R6 chroma inside range");

    // R2: constants only, quarter units, negative clamps to zero (R5)
    for (int i = 0; i < 9; i++) wr(i, 0);
    wr(9, 'h040);
    wr(10, 'h0FE);
    wr(11, 'h1FC0);
    wr(12, 1);
    pulseFrame();
    runPixel(24'hABCDEF, 24'h004010, "R2 constants");

    // R9: backpressure
    loadSet(2, 2);
    pulseFrame();
    @(negedge clk);
    outReady = 1'b0;
    fork
      begin
        for (int i = 1; i <= 4; i++) begin
          @(negedge clk);
          inValid = 1'b1;
          inPix   = 24'(i * 'h111111);
          while (!inReady) @(negedge clk);
          @(posedge clk);
        end
        @(negedge clk);
        inValid = 1'b0;
      end
      begin
        repeat (6) @(negedge clk);
        check(inReady == 1'b0, "R9 inReady low when full", 32'(inReady), 32'd0);
        check(outValid && outPix == 24'h111111, "R9 head pixel presented", 32'(outPix), 32'h111111);
        @(negedge clk);
        check(outPix == 24'h111111, "R9 held while stalled", 32'(outPix), 32'h111111);
        @(posedge clk);
        #1 outReady = 1'b1;
        for (int i = 1; i <= 4; i++) begin
          @(negedge clk);
          while (!outValid) @(negedge clk);
          check(outPix == 24'(i * 'h111111), "R9 order", 32'(outPix), 32'(i * 'h111111));
        end
      end
    join
    @(negedge clk);
    @(negedge clk);
    check(outValid == 1'b0, "R9 drained", 32'(outValid), 32'd0);

    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule